// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front-End

This block is the register side of a serial port that hangs off a simple memory-mapped bus. Inside a 1 KiB window it keeps a status word, a receive holding byte, a rate word, three control words and a guard word. Toward the line side it trades whole bytes. Incoming bytes arrive on a valid/ready stream, and outgoing bytes leave as single-cycle pulses. Bit timing, rate generation, parity, framing and queuing belong to other blocks. The rate, second and third control, and guard words are plain storage that this block never interprets.

A received byte is kept only when the port and its receiver are both enabled. Keeping it sets a "receive full" flag. While that flag is set the receive stream is stalled. If the receive interrupt enable is on, the interrupt line rises. Software empties the holding byte by reading it. Writes to the data offset send a byte at once, and they mark transmission complete. The status word has an unusual write rule. Small values load the word with the "transmit empty" flag forced on. Large values act as a clearing mask.

Top module: `uart_regfe`

## Requirements
- R1: After reset the status word reads 0x000000C0, every other offset reads zero, `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: `rx_ready` is high exactly while status bit 5 (receive full) is clear. A byte is taken in a cycle where `rx_valid` and `rx_ready` are both high.
- R3: A taken byte is discarded, and status bit 5 stays clear, unless control word A (offset 0x0C) has both bit 13 (port enable) and bit 2 (receiver enable) set.
- R4: A kept byte is stored, sets status bit 5, and raises `irq` on the next edge when control word A bit 5 (receive interrupt enable) is set.
- R5: A read of offset 0x04 returns the held byte zero-extended, keeping only the low 10 bits. On that edge it clears status bit 5 and lowers `irq`.
- R6: A write to offset 0x00 with a value of at most 0x3FF loads that value with bit 7 (transmit empty) forced to 1. A larger value is ANDed into the word. Either way, `irq` is lowered if bit 5 is then clear.
- R7: A write to offset 0x04 with a value below 0xF000 produces a one-cycle `tx_valid` pulse in the following cycle, carrying the low byte on `tx_data`. It also sets status bit 6 (transmission complete).
- R8: A write to offset 0x04 with a value of 0xF000 or more produces no pulse and leaves the status word unchanged.
- R9: A write to offset 0x0C stores all 32 bits. It raises `irq` when the written bit 5 is set and status bit 5 is already set.
- R10: Offsets 0x08, 0x10, 0x14 and 0x18 are plain 32-bit storage that reads back what was written.
- R11: Offsets that are undefined read as zero, and writes to them change no register. This covers offsets beyond 0x18 and offsets that are not a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | Outgoing byte pulse |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Receive interrupt, level |

## Verification
The bench goes after the corner cases that a plain read/write model would miss.

- **Status write threshold.** The bench writes status values at 0x3FF and just above it. A design that compares the wrong way would either mask when it should load, or load a value without the transmit-empty bit.
- **Ignored data writes.** The bench writes data values at 0xEFFF and at 0xF000. A design that ignores the limit would emit a stray pulse, or set the completion flag on an ignored write.
- **Interrupt ordering.** The bench arms the interrupt after a byte is already held, then reads the byte. A design that raises `irq` only at the moment of reception would never fire in this order, and one that forgets the read-side clear would hold `irq` high for good.
- **Disabled receiver.** The bench sends bytes while the port or its receiver is off. A design that latches them anyway would drop `rx_ready` and report data nobody enabled.

// File: rtl/uart_regfe_pkg.sv
package uart_regfe_pkg;

   typedef enum logic [2:0] {
      SEL_STAT  = 3'd0,
      SEL_DATA  = 3'd1,
      SEL_RATE  = 3'd2,
      SEL_CTLA  = 3'd3,
      SEL_CTLB  = 3'd4,
      SEL_CTLC  = 3'd5,
      SEL_GUARD = 3'd6,
      SEL_NONE  = 3'd7
   } reg_sel_e;

   // status word flag positions
   localparam int FULL_BIT  = 5;
   localparam int DONE_BIT  = 6;
   localparam int EMPTY_BIT = 7;

   // control word A positions
   localparam int RXEN_BIT  = 2;
   localparam int RXIE_BIT  = 5;
   localparam int PORTEN_BIT = 13;

   // number of plain storage words (rate, ctl A, ctl B, ctl C, guard)
   localparam int NUM_STORE = 5;

endpackage

// File: rtl/uart_regfe_decode.sv
module uart_regfe_decode
   import uart_regfe_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word_idx;
   logic             aligned;

   assign word_idx = addr[ADDR_W-1:2];
   assign aligned  = (addr[1:0] == 2'b00);

   always_comb begin
      sel = SEL_NONE;
      if (aligned && (word_idx < IDX_W'(7))) begin
         sel = reg_sel_e'(word_idx[2:0]);
      end
   end
endmodule

// File: rtl/uart_regfe_store.sv
module uart_regfe_store #(
   parameter int              W   = 32,
   parameter logic [W-1:0]    RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/uart_regfe_status.sv
module uart_regfe_status
   import uart_regfe_pkg::*;
#(
   parameter int                 DATA_W   = 32,
   parameter int                 BYTE_W   = 8,
   parameter logic [DATA_W-1:0]  STAT_RST = 32'h0000_00C0,
   parameter logic [DATA_W-1:0]  LOAD_MAX = 32'h0000_03FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr,
   input  logic              data_rd,
   input  logic              data_wr_ok,
   input  logic              ctla_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              irq_en,
   input  logic              rx_store,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [DATA_W-1:0] stat_q,
   output logic [BYTE_W-1:0] hold_q,
   output logic              irq_q
);
   logic [DATA_W-1:0] stat_d;
   logic [BYTE_W-1:0] hold_d;
   logic              irq_d;

   always_comb begin
      stat_d = stat_q;
      hold_d = hold_q;
      irq_d  = irq_q;
      if (stat_wr) begin
         if (wdata <= LOAD_MAX) begin
            stat_d            = wdata;
            stat_d[EMPTY_BIT] = 1'b1;
         end else begin
            stat_d = stat_q & wdata;
         end
         if (!stat_d[FULL_BIT]) irq_d = 1'b0;
      end
      if (data_wr_ok) stat_d[DONE_BIT] = 1'b1;
      if (ctla_wr && wdata[RXIE_BIT] && stat_q[FULL_BIT]) irq_d = 1'b1;
      if (data_rd) begin
         stat_d[FULL_BIT] = 1'b0;
         irq_d            = 1'b0;
      end
      if (rx_store) begin
         hold_d           = rx_byte;
         stat_d[FULL_BIT] = 1'b1;
         if (irq_en) irq_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= STAT_RST;
         hold_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         hold_q <= hold_d;
         irq_q  <= irq_d;
      end
   end
endmodule

// File: rtl/uart_regfe.sv
module uart_regfe
   import uart_regfe_pkg::*;
#(
   parameter int                 ADDR_W       = 10,
   parameter int                 DATA_W       = 32,
   parameter int                 BYTE_W       = 8,
   parameter int                 RD_KEEP      = 10,
   parameter logic [DATA_W-1:0]  STAT_RST     = 32'h0000_00C0,
   parameter logic [DATA_W-1:0]  LOAD_MAX     = 32'h0000_03FF,
   parameter logic [DATA_W-1:0]  TX_LIMIT     = 32'h0000_F000,
   parameter bit                 TX_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              irq
);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((64'd1 << RD_KEEP) - 64'd1);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("uart_regfe: ADDR_W too small for seven words");
   end
   if (DATA_W <= PORTEN_BIT) begin : g_bad_data
      $error("uart_regfe: DATA_W must hold control bit positions");
   end
   if (BYTE_W > DATA_W || RD_KEEP > DATA_W) begin : g_bad_byte
      $error("uart_regfe: byte or read mask wider than the bus");
   end

   reg_sel_e sel;
   logic     wr_hit, rd_hit;
   logic     stat_wr, data_rd, data_wr, data_wr_ok, ctla_wr;
   logic     rx_store;

   logic [DATA_W-1:0] stat_q;
   logic [BYTE_W-1:0] hold_q;
   logic [DATA_W-1:0] ctla_q;
   logic [DATA_W-1:0] store_q [NUM_STORE];
   logic [NUM_STORE-1:0] store_we;

   uart_regfe_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign wr_hit     = bus_sel &&  bus_wr;
   assign rd_hit     = bus_sel && !bus_wr;
   assign stat_wr    = wr_hit && (sel == SEL_STAT);
   assign data_wr    = wr_hit && (sel == SEL_DATA);
   assign data_rd    = rd_hit && (sel == SEL_DATA);
   assign ctla_wr    = wr_hit && (sel == SEL_CTLA);
   assign data_wr_ok = data_wr && (bus_wdata < TX_LIMIT);

   // plain storage words, slot k maps to select code k+2
   for (genvar k = 0; k < NUM_STORE; k++) begin : g_store
      assign store_we[k] = wr_hit && (sel == reg_sel_e'(k + 2));
      uart_regfe_store #(.W(DATA_W), .RST('0)) st_i (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (store_we[k]),
         .d     (bus_wdata),
         .q     (store_q[k])
      );
   end

   assign ctla_q   = store_q[SEL_CTLA - 2];
   assign rx_ready = !stat_q[FULL_BIT];
   assign rx_store = rx_valid && rx_ready &&
                     ctla_q[PORTEN_BIT] && ctla_q[RXEN_BIT];

   uart_regfe_status #(
      .DATA_W   (DATA_W),
      .BYTE_W   (BYTE_W),
      .STAT_RST (STAT_RST),
      .LOAD_MAX (LOAD_MAX)
   ) stat_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_wr    (stat_wr),
      .data_rd    (data_rd),
      .data_wr_ok (data_wr_ok),
      .ctla_wr    (ctla_wr),
      .wdata      (bus_wdata),
      .irq_en     (ctla_q[RXIE_BIT]),
      .rx_store   (rx_store),
      .rx_byte    (rx_data),
      .stat_q     (stat_q),
      .hold_q     (hold_q),
      .irq_q      (irq)
   );

   // transmit side: registered pulse or pass-through
   if (TX_REGISTERED) begin : g_tx_reg
      logic              tv_q;
      logic [BYTE_W-1:0] td_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tv_q <= 1'b0;
            td_q <= '0;
         end else begin
            tv_q <= data_wr_ok;
            if (data_wr_ok) td_q <= bus_wdata[BYTE_W-1:0];
         end
      end
      assign tx_valid = tv_q;
      assign tx_data  = td_q;
   end else begin : g_tx_comb
      assign tx_valid = data_wr_ok;
      assign tx_data  = bus_wdata[BYTE_W-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         unique case (sel)
            SEL_STAT:  bus_rdata = stat_q;
            SEL_DATA:  bus_rdata = DATA_W'(hold_q) & KEEP_MASK;
            SEL_NONE:  bus_rdata = '0;
            default:   bus_rdata = store_q[sel - 2];
         endcase
      end
   end
endmodule

// File: rtl/uart_regfe_chk.sv
module uart_regfe_chk #(
   parameter int                ADDR_W   = 10,
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] LOAD_MAX = 32'h0000_03FF,
   parameter logic [DATA_W-1:0] TX_LIMIT = 32'h0000_F000,
   parameter bit                TX_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic              irq,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] ctla_q
);
   logic at_stat, at_data, at_ctla, rx_take, port_on;
   assign at_stat = bus_sel && (bus_addr == ADDR_W'(0));
   assign at_data = bus_sel && (bus_addr == ADDR_W'(4));
   assign at_ctla = bus_sel && (bus_addr == ADDR_W'(12));
   assign rx_take = rx_valid && rx_ready;
   assign port_on = ctla_q[13] && ctla_q[2];

   // R2
   take_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_take && port_on && !(at_data && !bus_wr) |=> !rx_ready);

   // R3
   drop_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_take && !port_on && !(at_stat && bus_wr) |=> rx_ready);

   // R5
   read_lowers_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_data && !bus_wr && !rx_take |=> !irq);

   // R6
   small_load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_stat && bus_wr && (bus_wdata <= LOAD_MAX) |=> stat_q[7]);

   // R8
   big_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_data && bus_wr && (bus_wdata >= TX_LIMIT) && !rx_take |=> $stable(stat_q));

   // R9
   arm_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_ctla && bus_wr && bus_wdata[5] && stat_q[5] |=> irq);

   if (TX_REGISTERED) begin : g_reg
      // R7
      tx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tx_valid |-> $past(at_data && bus_wr && (bus_wdata < TX_LIMIT)));
   end else begin : g_comb
      // R7
      tx_origin_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tx_valid |-> (at_data && bus_wr && (bus_wdata < TX_LIMIT)));
   end
endmodule

bind uart_regfe uart_regfe_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .LOAD_MAX      (LOAD_MAX),
   .TX_LIMIT      (TX_LIMIT),
   .TX_REGISTERED (TX_REGISTERED)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .irq       (irq),
   .stat_q    (stat_q),
   .ctla_q    (ctla_q)
);

// File: tb/uart_regfe_tb_top.sv
module uart_regfe_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_data;

   int errors = 0;
   int checks = 0;
   int tx_seen = 0;
   logic [7:0] tx_last = '0;

   // model state
   logic [31:0] m_stat, m_ctla, m_rate, m_ctlb, m_ctlc, m_guard;
   logic [7:0]  m_hold;
   logic        m_irq;
   int          m_tx;
   logic [7:0]  m_tx_last;

   always #5 clk = ~clk;

   uart_regfe dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   always @(negedge clk) begin
      if (tx_valid) begin
         tx_seen <= tx_seen + 1;
         tx_last <= tx_data;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_stat = 32'hC0; m_ctla = 0; m_rate = 0; m_ctlb = 0; m_ctlc = 0;
      m_guard = 0; m_hold = 0; m_irq = 0; m_tx = 0; m_tx_last = 0;
   endtask

   function automatic logic [31:0] m_peek(input logic [9:0] a);
      case (a)
         10'h00: return m_stat;
         10'h04: return {24'd0, m_hold};
         10'h08: return m_rate;
         10'h0C: return m_ctla;
         10'h10: return m_ctlb;
         10'h14: return m_ctlc;
         10'h18: return m_guard;
         default: return 32'd0;
      endcase
   endfunction

   task automatic m_write(input logic [9:0] a, input logic [31:0] v);
      case (a)
         10'h00: begin
            if (v <= 32'h3FF) m_stat = v | 32'h80; else m_stat = m_stat & v;
            if (!m_stat[5]) m_irq = 0;
         end
         10'h04: if (v < 32'hF000) begin
            m_stat[6] = 1; m_tx++; m_tx_last = v[7:0];
         end
         10'h08: m_rate = v;
         10'h0C: begin m_ctla = v; if (v[5] && m_stat[5]) m_irq = 1; end
         10'h10: m_ctlb = v;
         10'h14: m_ctlc = v;
         10'h18: m_guard = v;
         default: ;
      endcase
   endtask

   task automatic bus_write(input logic [9:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      #1;
      m_write(a, v);
   endtask

   task automatic bus_read(input logic [9:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 v = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 0;
      #1;
      if (a == 10'h04) begin m_stat[5] = 0; m_irq = 0; end
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1; rx_data = b;
      #1 check("R2 ready", {31'd0, rx_ready}, {31'd0, !m_stat[5]});
      @(posedge clk);
      @(negedge clk);
      rx_valid = 0;
      #1;
      if (!m_stat[5] && m_ctla[13] && m_ctla[2]) begin
         m_hold = b; m_stat[5] = 1;
         if (m_ctla[5]) m_irq = 1;
      end
   endtask

   task automatic read_check(input string req, input logic [9:0] a);
      logic [31:0] exp, got;
      exp = m_peek(a);
      bus_read(a, got);
      check(req, got, exp);
   endtask

   task automatic state_check(input string req);
      check({req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
      check({req, " tx count"}, tx_seen, m_tx);
      if (m_tx > 0) check({req, " tx byte"}, {24'd0, tx_last}, {24'd0, m_tx_last});
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1;
      // R1 reset values
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 tx_valid", {31'd0, tx_valid}, 0);
      check("R1 rx_ready", {31'd0, rx_ready}, 1);
      for (int i = 0; i < 7; i++) read_check("R1 reset read", 10'(i * 4));

      // R3 receiver off: byte dropped
      bus_write(10'h0C, 32'h0000_2000);
      rx_push(8'h11);
      check("R3 dropped keeps ready", {31'd0, rx_ready}, 1);
      read_check("R3 status unchanged", 10'h00);

      // R4 kept byte without interrupt enable
      bus_write(10'h0C, 32'h0000_2004);
      rx_push(8'hA5);
      check("R4 full stalls", {31'd0, rx_ready}, 0);
      state_check("R4");
      rx_push(8'h5A);                 // refused while full (R2)
      // R9 arm after reception
      bus_write(10'h0C, 32'h0000_2024);
      check("R9 irq raised", {31'd0, irq}, 1);
      // R5 read clears
      read_check("R5 data read", 10'h04);
      state_check("R5");
      check("R5 ready back", {31'd0, rx_ready}, 1);
      // R4 with interrupt enable on
      rx_push(8'h3C);
      check("R4 irq", {31'd0, irq}, 1);
      // R6 status load lowers irq
      bus_write(10'h00, 32'h0000_0000);
      read_check("R6 load 0", 10'h00);
      state_check("R6");
      bus_write(10'h00, 32'h0000_03FF);
      read_check("R6 load 3FF", 10'h00);
      bus_write(10'h00, 32'h0000_0400);
      read_check("R6 mask 400", 10'h00);
      // R7 / R8 data write limits
      bus_write(10'h04, 32'h0000_EFFF);
      state_check("R7 EFFF");
      read_check("R7 done flag", 10'h00);
      bus_write(10'h00, 32'hFFFF_FFBF);
      bus_write(10'h04, 32'h0000_F000);
      state_check("R8 F000");
      read_check("R8 status kept", 10'h00);
      // R10 plain storage
      bus_write(10'h08, 32'hDEAD_BEEF);
      bus_write(10'h10, 32'h1234_5678);
      bus_write(10'h14, 32'hFFFF_0000);
      bus_write(10'h18, 32'h0000_FFFF);
      for (int i = 2; i < 7; i++) read_check("R10 readback", 10'(i * 4));
      // R11 undefined offsets
      bus_write(10'h1C, 32'hFFFF_FFFF);
      bus_write(10'h09, 32'h0);
      read_check("R11 hole 1C", 10'h1C);
      read_check("R11 unaligned", 10'h0D);
      read_check("R11 rate intact", 10'h08);

      // random phase
      for (int n = 0; n < 600; n++) begin
         int op;
         logic [31:0] r;
         op = $urandom_range(0, 9);
         r = $urandom;
         case (op)
            0: bus_write(10'h00, ($urandom_range(0, 1) != 0) ? (r & 32'h3FF) : (r | 32'h400));
            1: bus_write(10'h04, ($urandom_range(0, 1) != 0) ? (r & 32'hFFFF) : r);
            2: bus_write(10'h0C, r | (($urandom_range(0, 3) != 0) ? 32'h2004 : 32'h0));
            3: bus_write(10'($urandom_range(2, 6) * 4), r);
            4: bus_write(10'($urandom_range(7, 255) * 4), r);
            5, 6: rx_push(r[7:0]);
            7: read_check("R5 random data", 10'h04);
            8: read_check("R6 random status", 10'h00);
            default: read_check("R10 random store", 10'($urandom_range(2, 7) * 4));
         endcase
         state_check("R4 random");
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule